// File: doc/BRIEF.md
# Event Queue Record Writer

The block takes event records from a producer inside the chip and stores each one in a circular event ring held in system memory. It issues each store through a simple write port: a request with address and data, then a response that reports success or error. The ring slot is chosen by a producer pointer. The pointer's low bits give the slot index, and its top bit is a lap (wrap) marker. The consumer side supplies its own pointer in the same encoding, and the block compares the two pointers to decide whether the ring is full or empty.

Records are only written while the queue-enable input is high. A record that arrives while the ring is full is thrown away, and a saturating drop counter records the loss. A record that is stored into a ring that was empty produces a one-cycle interrupt pulse. The pulse tells the consumer that there is new work. A store that comes back with an error is treated as not having happened.

Top module: `evq_writer`

## Requirements
- R1: When `q_enable` is low, an accepted record is discarded. No memory request is issued, and `prod_ptr`, `drop_count` and `evt_irq` are unaffected.
- R2: When the ring is full, an accepted record is discarded, no memory request is issued and `prod_ptr` stays the same. The ring is full when the index bits `[IDX_W-1:0]` of `prod_ptr` and `cons_ptr` are equal and their bit `IDX_W` differs. In that case `drop_count` goes up by one, and it saturates at all ones.
- R3: A record accepted into a ring that is not full produces one request. The request carries `mem_req_addr = q_base + index * 2**ENTRY_LOG2`, where index is `prod_ptr[IDX_W-1:0]`, and `mem_req_data` equal to the record.
- R4: A response with no error moves `prod_ptr` on by one in the cycle after the response. When the index is at 2**IDX_W-1, it returns to 0 and bit `IDX_W` inverts. `prod_ptr` does not change at any other time.
- R5: A response with `mem_rsp_err` high leaves `prod_ptr` unchanged and produces no interrupt.
- R6: `evt_irq` is high for exactly one cycle, in the cycle after a response with no error, and only when the ring was empty at the moment the record was accepted. The ring is empty when `prod_ptr` equals `cons_ptr`.
- R7: `rec_ready` is low from the cycle after a record is accepted for writing until the cycle after its response. A request held with `mem_req_ready` low keeps its address and data stable.
- R8: After reset, `prod_ptr` and `drop_count` are 0, `evt_irq` and `mem_req_valid` are low, and `rec_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| q_enable | input | 1 | Queue enable; records are discarded while low |
| q_base | input | ADDR_W | Byte address of ring slot 0 |
| cons_ptr | input | IDX_W+1 | Consumer pointer: lap bit on top, slot index below |
| rec_valid | input | 1 | Record offered |
| rec_ready | output | 1 | Record can be taken |
| rec_data | input | REC_W | Record contents |
| mem_req_valid | output | 1 | Memory write request pending |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | ADDR_W | Write address |
| mem_req_data | output | REC_W | Write data |
| mem_rsp_valid | input | 1 | Write response present |
| mem_rsp_err | input | 1 | Write failed |
| prod_ptr | output | IDX_W+1 | Producer pointer, same encoding as `cons_ptr` |
| evt_irq | output | 1 | One-cycle pulse when a record lands in an empty ring |
| drop_count | output | DROP_W | Saturating count of records lost to a full ring |

## Verification
A producer pointer that is off by one shows up at once on `prod_ptr`, and on the next stored record as a wrong `mem_req_addr`. A lap bit that is wrong makes the ring look full or empty when it is not. That shows as a dropped record, with `drop_count` rising in the cycle after acceptance, or as a missing or extra `evt_irq`. A stale empty flag captured at acceptance is only visible one cycle after the response, as an interrupt that should not be there or one that is absent. For that reason the bench checks the interrupt both in the cycle after each response and in the cycle after that.

// File: rtl/evq_pkg.sv
// Shared types for the event queue record writer.
package evq_pkg;

    // Write sequencer states: waiting for a record, issuing the request,
    // awaiting the memory response.
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_REQ  = 2'd1,
        WR_WAIT = 2'd2
    } wr_state_e;

endpackage

// File: rtl/evq_ring_ptr.sv
// Producer pointer of a lap-marked ring.
// Holds an (IDX_W+1)-bit pointer: the top bit is the lap marker and the low
// bits are the slot index. Compares the pointer with the consumer pointer
// to flag full and empty.
// Assumes the consumer pointer uses the same encoding and never passes the
// producer.
module evq_ring_ptr #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic [IDX_W:0]   cons_ptr,
    output logic [IDX_W:0]   prod_ptr,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = IDX_W + 1;

    logic idx_same;
    logic lap_same;

    // Compare the index bits and the lap bits separately.
    always_comb begin
        idx_same = (prod_ptr[IDX_W-1:0] == cons_ptr[IDX_W-1:0]);
        lap_same = (prod_ptr[IDX_W] == cons_ptr[IDX_W]);
        full     = idx_same && !lap_same;
        empty    = idx_same && lap_same;
    end

    // Step the pointer. A binary carry out of the index bits toggles the lap bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_ptr <= '0;
        end else if (advance) begin
            prod_ptr <= PTR_W'(prod_ptr + 1'b1);
        end
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(prod_ptr)); // R4

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> prod_ptr == PTR_W'($past(prod_ptr) + 1'b1)); // R4

endmodule

// File: rtl/evq_drop_ctr.sv
// Saturating counter of records lost to a full ring.
// Assumes bump is high for one cycle per dropped record.
module evq_drop_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count drops and stop at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump && (count != CNT_MAX)) begin
            count <= count + 1'b1;
        end
    end

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bump && count != CNT_MAX) |=> count == CNT_W'($past(count) + 1'b1)); // R2

    AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bump |=> $stable(count)); // R2

endmodule

// File: rtl/evq_wr_ctrl.sv
// Write sequencer for the event ring.
// Takes one record at a time. It discards the record when the queue is
// disabled or the ring is full. Otherwise it captures the record, the slot
// address and the empty state, then runs one request/response exchange.
// Assumes the memory returns exactly one response per accepted request.
// A response that arrives while no request is outstanding is ignored.
module evq_wr_ctrl
    import evq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int REC_W      = 256,
    parameter int IDX_W      = 4,
    parameter int ENTRY_LOG2 = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic [ADDR_W-1:0] q_base,
    input  logic              full,
    input  logic              empty,
    input  logic [IDX_W-1:0]  prod_idx,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [REC_W-1:0]  rec_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [REC_W-1:0]  mem_req_data,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              advance,
    output logic              drop,
    output logic              evt_irq
);

    wr_state_e         state;
    logic              accept;
    logic              take;
    logic              was_empty;
    logic              rsp_here;
    logic [ADDR_W-1:0] slot_off;

    // Decode the handshake outcomes for this cycle.
    always_comb begin
        rec_ready     = (state == WR_IDLE);
        accept        = rec_valid && rec_ready;
        take          = accept && q_enable && !full;
        drop          = accept && q_enable && full;
        rsp_here      = (state == WR_WAIT) && mem_rsp_valid;
        advance       = rsp_here && !mem_rsp_err;
        mem_req_valid = (state == WR_REQ);
        slot_off      = ADDR_W'(prod_idx) << ENTRY_LOG2;
    end

    // Sequence one write, capture its operands and raise the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= WR_IDLE;
            was_empty    <= 1'b0;
            evt_irq      <= 1'b0;
            mem_req_addr <= '0;
            mem_req_data <= '0;
        end else begin
            evt_irq <= 1'b0;
            case (state)
                WR_IDLE: begin
                    if (take) begin
                        state        <= WR_REQ;
                        was_empty    <= empty;
                        mem_req_addr <= q_base + slot_off;
                        mem_req_data <= rec_data;
                    end
                end
                WR_REQ: begin
                    if (mem_req_ready) begin
                        state <= WR_WAIT;
                    end
                end
                WR_WAIT: begin
                    if (mem_rsp_valid) begin
                        state   <= WR_IDLE;
                        evt_irq <= !mem_rsp_err && was_empty;
                    end
                end
                default: state <= WR_IDLE;
            endcase
        end
    end

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !q_enable) |=> !mem_req_valid && !evt_irq); // R1

    AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !mem_req_valid); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !rec_ready); // R7

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)); // R7

    AST_IRQ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_irq |=> !evt_irq); // R6

    AST_ERR_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_here && mem_rsp_err) |=> !evt_irq); // R5

endmodule

// File: rtl/evq_writer.sv
// Event queue record writer, top level.
// Joins the ring pointer, the write sequencer and the drop counter.
// Assumes q_base is aligned to the slot size and holds steady while a write
// is outstanding.
module evq_writer #(
    parameter int ADDR_W     = 32,
    parameter int REC_W      = 256,
    parameter int IDX_W      = 4,
    parameter int ENTRY_LOG2 = 5,
    parameter int DROP_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_enable,
    input  logic [ADDR_W-1:0] q_base,
    input  logic [IDX_W:0]    cons_ptr,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [REC_W-1:0]  rec_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [REC_W-1:0]  mem_req_data,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic [IDX_W:0]    prod_ptr,
    output logic              evt_irq,
    output logic [DROP_W-1:0] drop_count
);

    logic advance;
    logic drop;
    logic full;
    logic empty;

    evq_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .cons_ptr (cons_ptr),
        .prod_ptr (prod_ptr),
        .full     (full),
        .empty    (empty)
    );

    evq_wr_ctrl #(
        .ADDR_W     (ADDR_W),
        .REC_W      (REC_W),
        .IDX_W      (IDX_W),
        .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_enable      (q_enable),
        .q_base        (q_base),
        .full          (full),
        .empty         (empty),
        .prod_idx      (prod_ptr[IDX_W-1:0]),
        .rec_valid     (rec_valid),
        .rec_ready     (rec_ready),
        .rec_data      (rec_data),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .advance       (advance),
        .drop          (drop),
        .evt_irq       (evt_irq)
    );

    evq_drop_ctr #(.CNT_W(DROP_W)) u_drop (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (drop),
        .count (drop_count)
    );

    AST_ERR_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_err) |=> $stable(prod_ptr)); // R5

    AST_IDLE_RSP_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && rec_ready) |=> $stable(prod_ptr) && !evt_irq); // R4

endmodule

// File: tb/sim_evq_writer.sv
// Directed bench for the event queue record writer: one task per scenario.
module sim_evq_writer;

    localparam int ADDR_W     = 16;
    localparam int REC_W      = 32;
    localparam int IDX_W      = 2;
    localparam int ENTRY_LOG2 = 5;
    localparam int DROP_W     = 2;
    localparam logic [ADDR_W-1:0] BASE = 16'h1000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              q_enable = 1'b0;
    logic [ADDR_W-1:0] q_base = BASE;
    logic [IDX_W:0]    cons_ptr = '0;
    logic              rec_valid = 1'b0;
    logic              rec_ready;
    logic [REC_W-1:0]  rec_data = '0;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b0;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [REC_W-1:0]  mem_req_data;
    logic              mem_rsp_valid = 1'b0;
    logic              mem_rsp_err = 1'b0;
    logic [IDX_W:0]    prod_ptr;
    logic              evt_irq;
    logic [DROP_W-1:0] drop_count;

    int checks = 0;
    int fails  = 0;
    logic [IDX_W:0] exp_ptr = '0;

    evq_writer #(
        .ADDR_W(ADDR_W), .REC_W(REC_W), .IDX_W(IDX_W),
        .ENTRY_LOG2(ENTRY_LOG2), .DROP_W(DROP_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .q_enable(q_enable), .q_base(q_base),
        .cons_ptr(cons_ptr), .rec_valid(rec_valid), .rec_ready(rec_ready),
        .rec_data(rec_data), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_req_data(mem_req_data), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_err(mem_rsp_err), .prod_ptr(prod_ptr), .evt_irq(evt_irq),
        .drop_count(drop_count)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one record for one cycle; returns at the negedge after acceptance.
    task automatic push(input logic [REC_W-1:0] d);
        @(negedge clk);
        rec_valid = 1'b1;
        rec_data  = d;
        @(negedge clk);
        rec_valid = 1'b0;
    endtask

    // Serve the pending request and check the address, data, pointer and irq.
    task automatic serve(input logic err, input int hold, input logic [REC_W-1:0] d,
                         input logic exp_irq, input string tag);
        logic [ADDR_W-1:0] exp_addr;
        exp_addr = BASE + (ADDR_W'(exp_ptr[IDX_W-1:0]) << ENTRY_LOG2);
        chk("R3", {tag, " req valid"}, 64'(mem_req_valid), 64'd1);
        chk("R3", {tag, " addr"}, 64'(mem_req_addr), 64'(exp_addr));
        chk("R3", {tag, " data"}, 64'(mem_req_data), 64'(d));
        chk("R7", {tag, " ready low in req"}, 64'(rec_ready), 64'd0);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R7", {tag, " req held"}, 64'(mem_req_valid), 64'd1);
            chk("R7", {tag, " addr held"}, 64'(mem_req_addr), 64'(exp_addr));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R7", {tag, " ready low in wait"}, 64'(rec_ready), 64'd0);
        chk("R7", {tag, " req dropped"}, 64'(mem_req_valid), 64'd0);
        mem_rsp_valid = 1'b1;
        mem_rsp_err   = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (!err) exp_ptr = exp_ptr + 1'b1;
        chk(err ? "R5" : "R6", {tag, " irq"}, 64'(evt_irq), 64'(exp_irq));
        chk(err ? "R5" : "R4", {tag, " ptr"}, 64'(prod_ptr), 64'(exp_ptr));
        chk("R7", {tag, " ready back"}, 64'(rec_ready), 64'd1);
        @(negedge clk);
        chk("R6", {tag, " irq one cycle"}, 64'(evt_irq), 64'd0);
    endtask

    task automatic t_reset();
        chk("R8", "ptr", 64'(prod_ptr), 64'd0);
        chk("R8", "drops", 64'(drop_count), 64'd0);
        chk("R8", "irq", 64'(evt_irq), 64'd0);
        chk("R8", "req", 64'(mem_req_valid), 64'd0);
        chk("R8", "ready", 64'(rec_ready), 64'd1);
    endtask

    task automatic t_disabled();
        q_enable = 1'b0;
        push(32'hDEAD0001);
        chk("R1", "no req", 64'(mem_req_valid), 64'd0);
        chk("R1", "ptr", 64'(prod_ptr), 64'd0);
        chk("R1", "drops", 64'(drop_count), 64'd0);
        chk("R1", "irq", 64'(evt_irq), 64'd0);
        q_enable = 1'b1;
    endtask

    task automatic t_write(input logic [REC_W-1:0] d, input logic err,
                           input int hold, input logic exp_irq, input string tag);
        push(d);
        serve(err, hold, d, exp_irq, tag);
    endtask

    task automatic t_drop(input logic [DROP_W-1:0] exp_cnt, input string tag);
        push(32'hBAD0BAD0);
        chk("R2", {tag, " no req"}, 64'(mem_req_valid), 64'd0);
        chk("R2", {tag, " ptr"}, 64'(prod_ptr), 64'(exp_ptr));
        chk("R2", {tag, " drops"}, 64'(drop_count), 64'(exp_cnt));
        chk("R2", {tag, " ready"}, 64'(rec_ready), 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_write(32'hA0000001, 1'b0, 0, 1'b1, "first into empty");   // R6 R4
        t_write(32'hA0000002, 1'b0, 2, 1'b0, "second not empty");   // R6 R7
        t_write(32'hA0000003, 1'b1, 3, 1'b0, "error response");     // R5
        t_write(32'hA0000004, 1'b0, 0, 1'b0, "slot two");           // R4
        t_write(32'hA0000005, 1'b0, 1, 1'b0, "slot three wrap");    // R4
        chk("R4", "lap bit toggled", 64'(prod_ptr), 64'h4);
        t_drop(2'd1, "full one");
        t_drop(2'd2, "full two");
        t_drop(2'd3, "full three");
        t_drop(2'd3, "full saturate");
        cons_ptr = 3'b011;
        t_write(32'hA0000006, 1'b0, 0, 1'b0, "after partial consume");
        cons_ptr = 3'b101;
        t_write(32'hA0000007, 1'b0, 0, 1'b1, "empty after lap");    // R6
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule